// File: doc/BRIEF.md
# Cascadable Bidirectional Column Data Loader

This block fills the column data register of one column-driver chip during a display line. A single start pulse, taken in on one of two start pins, launches a token that walks through a chain of 64 stages, one stage per clock. On every clock while the token is walking, the stage it occupies captures a 36-bit input word, which holds six 6-bit gray values (two RGB pixels). After 64 clocks all 384 columns hold fresh data.

A direction input picks which start pin listens and which one drives, and it also mirrors the order in which the columns fill. This lets chips be chained in either direction along a panel edge. When the last stage has captured, the block emits a one-clock carry pulse on its output start pin, which serves as the start pulse of the next chip in the chain. An inversion control, sampled together with the data, stores each gray value bit-inverted when high.

Top module: `col_loader`

## Requirements
- R1: While reset is high, and on the first cycle after it, both start output pins are low, and no column is written until a start pulse has been taken in.
- R2: With `dir_fwd` high only `start_r_in` launches a line; with it low only `start_l_in` does. A pulse on the other pin changes no column and produces no carry.
- R3: After a rising edge that samples a start pulse (that edge captures nothing), the following 64 rising edges capture into stages 0, 1, ... 63 in turn, one stage per edge.
- R4: With `dir_fwd` high, gray value g of the word (bits 6g+5..6g, bit 6g the LSB) captured by stage s lands in column 6s+g, where column c is `col_data[6c+5:6c]`.
- R5: With `dir_fwd` low, gray value g captured by stage s lands in column 383-(6s+g).
- R6: When `invert` is high at a capture edge, each stored 6-bit value is the bitwise inverse of its input group; when low, it is stored unchanged.
- R7: The carry pulse is high for exactly the one cycle that follows the 64th capture edge, on `start_l_out` when `dir_fwd` is high and on `start_r_out` when it is low.
- R8: `start_l_oe` equals `dir_fwd` and `start_r_oe` equals its inverse, so only the pin acting as output is driven; the input-role pin's output stays low.
- R9: After the 64th capture the loader is idle: input words are ignored and all columns hold their values until the next start pulse.
- R10: A start pulse taken in while a line is being loaded restarts at stage 0; that edge captures nothing and no carry is emitted for the abandoned line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of pointer and carry |
| dir_fwd | input | 1 | 1: right pin in, fill from column 0; 0: left pin in, fill from column 383 |
| start_r_in | input | 1 | Right start pin, input value |
| start_l_in | input | 1 | Left start pin, input value |
| pix_word | input | 36 | Six 6-bit gray values |
| invert | input | 1 | Store gray values inverted when high |
| start_r_out | output | 1 | Right start pin, carry output value |
| start_r_oe | output | 1 | Right start pin output enable |
| start_l_out | output | 1 | Left start pin, carry output value |
| start_l_oe | output | 1 | Left start pin output enable |
| col_data | output | 2304 | 384 columns of 6 bits, column c at bits 6c+5..6c |

## Verification
Lines are loaded in both directions with random words so that any mix-up of stage order, group order within a stage, or mirrored slot appears as a column mismatch against the reference. Inversion is tried constant off, and alternating per stage, which separates a control sampled at the capture edge from one latched per line. Pulses on the wrong start pin, idle cycles with changing data after a line, and a restart in the middle of a line show whether the token launches, stops and resets exactly where the requirements say, while the carry pin is compared each cycle to show its single-cycle timing and pin choice.

// File: rtl/colld_pkg.sv
package colld_pkg;
  localparam int unsigned STAGES_DEF = 64;
  localparam int unsigned GROUPS_DEF = 6;
  localparam int unsigned GRAY_W_DEF = 6;
endpackage

// File: rtl/colld_ptr.sv
module colld_ptr #(
  parameter int unsigned STAGES = colld_pkg::STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [STAGES-1:0] wen,
  output logic              last
);
  logic [STAGES-1:0] tok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q <= '0;
    end else if (start) begin
      tok_q <= {{(STAGES-1){1'b0}}, 1'b1};
    end else begin
      tok_q <= tok_q << 1;
    end
  end

  assign wen  = start ? '0 : tok_q;
  assign last = wen[STAGES-1];
endmodule

// File: rtl/colld_map.sv
module colld_map #(
  parameter int unsigned STAGES = colld_pkg::STAGES_DEF,
  parameter int unsigned GROUPS = colld_pkg::GROUPS_DEF,
  parameter int unsigned GRAY_W = colld_pkg::GRAY_W_DEF,
  localparam int unsigned WORD_W = GROUPS * GRAY_W
) (
  input  logic              dir_fwd,
  input  logic              invert,
  input  logic [WORD_W-1:0] word_in,
  input  logic [STAGES-1:0] wen_log,
  output logic [WORD_W-1:0] word_phys,
  output logic [STAGES-1:0] wen_phys
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GRAY_W-1:0] pick;
    assign pick = dir_fwd ? word_in[g*GRAY_W +: GRAY_W]
                          : word_in[(GROUPS-1-g)*GRAY_W +: GRAY_W];
    assign word_phys[g*GRAY_W +: GRAY_W] = pick ^ {GRAY_W{invert}};
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_slot
    assign wen_phys[s] = dir_fwd ? wen_log[s] : wen_log[STAGES-1-s];
  end
endmodule

// File: rtl/colld_store.sv
module colld_store #(
  parameter int unsigned STAGES = colld_pkg::STAGES_DEF,
  parameter int unsigned WORD_W = colld_pkg::GROUPS_DEF * colld_pkg::GRAY_W_DEF
) (
  input  logic                     clk,
  input  logic [STAGES-1:0]        wen,
  input  logic [WORD_W-1:0]        word,
  output logic [STAGES*WORD_W-1:0] cols
);
  for (genvar s = 0; s < STAGES; s++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wen[s]) slot_q <= word;
    end
    assign cols[s*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/col_loader.sv
module col_loader #(
  parameter int unsigned STAGES = colld_pkg::STAGES_DEF,
  parameter int unsigned GROUPS = colld_pkg::GROUPS_DEF,
  parameter int unsigned GRAY_W = colld_pkg::GRAY_W_DEF,
  localparam int unsigned WORD_W = GROUPS * GRAY_W,
  localparam int unsigned NCOL   = STAGES * GROUPS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dir_fwd,
  input  logic                   start_r_in,
  input  logic                   start_l_in,
  input  logic [WORD_W-1:0]      pix_word,
  input  logic                   invert,
  output logic                   start_r_out,
  output logic                   start_r_oe,
  output logic                   start_l_out,
  output logic                   start_l_oe,
  output logic [NCOL*GRAY_W-1:0] col_data
);
  logic              start_act;
  logic [STAGES-1:0] wen_log;
  logic [STAGES-1:0] wen_phys;
  logic [WORD_W-1:0] word_phys;
  logic              last_cap;
  logic              carry_q;

  assign start_act = dir_fwd ? start_r_in : start_l_in;

  colld_ptr #(.STAGES(STAGES)) i_ptr (
    .clk(clk), .rst(rst), .start(start_act), .wen(wen_log), .last(last_cap)
  );

  colld_map #(.STAGES(STAGES), .GROUPS(GROUPS), .GRAY_W(GRAY_W)) i_map (
    .dir_fwd(dir_fwd), .invert(invert), .word_in(pix_word),
    .wen_log(wen_log), .word_phys(word_phys), .wen_phys(wen_phys)
  );

  colld_store #(.STAGES(STAGES), .WORD_W(WORD_W)) i_store (
    .clk(clk), .wen(wen_phys), .word(word_phys), .cols(col_data)
  );

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= last_cap;
  end

  assign start_l_oe  = dir_fwd;
  assign start_r_oe  = ~dir_fwd;
  assign start_l_out = carry_q & dir_fwd;
  assign start_r_out = carry_q & ~dir_fwd;
endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int unsigned STAGES = 64,
  parameter int unsigned DW     = 2304
) (
  input logic              clk,
  input logic              rst,
  input logic              dir_fwd,
  input logic              start_r_in,
  input logic              start_l_in,
  input logic              start_r_out,
  input logic              start_l_out,
  input logic              start_r_oe,
  input logic              start_l_oe,
  input logic [DW-1:0]     col_data,
  input logic [STAGES-1:0] wen
);
  localparam int unsigned CW = $clog2(STAGES + 1);
  logic          act;
  logic          carry_any;
  logic [CW-1:0] left_q;

  assign act       = dir_fwd ? start_r_in : start_l_in;
  assign carry_any = start_r_out | start_l_out;

  always_ff @(posedge clk) begin
    if (rst)           left_q <= '0;
    else if (act)      left_q <= CW'(STAGES);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  p_one_stage_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(wen));
  p_carry_due_r3: assert property (@(posedge clk) disable iff (rst)
    (left_q == 1 && !act) |=> carry_any);
  p_carry_only_r7: assert property (@(posedge clk) disable iff (rst)
    !(left_q == 1 && !act) |=> !carry_any);
  p_carry_once_r7: assert property (@(posedge clk) disable iff (rst)
    carry_any |=> !carry_any);
  p_oe_split_r8: assert property (@(posedge clk) disable iff (rst)
    start_l_oe != start_r_oe);
  p_in_pin_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (dir_fwd |-> !start_r_out) and (!dir_fwd |-> !start_l_out));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (left_q == 0 && !act) |=> $stable(col_data));
endmodule

bind col_loader col_loader_chk #(.STAGES(STAGES), .DW(NCOL*GRAY_W)) i_chk (
  .clk(clk), .rst(rst), .dir_fwd(dir_fwd),
  .start_r_in(start_r_in), .start_l_in(start_l_in),
  .start_r_out(start_r_out), .start_l_out(start_l_out),
  .start_r_oe(start_r_oe), .start_l_oe(start_l_oe),
  .col_data(col_data), .wen(wen_phys)
);

// File: tb/test_col_loader.sv
module test_col_loader;
  localparam int NST = 64;
  localparam int NG  = 6;
  localparam int NC  = NST * NG;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dir_fwd = 1'b1;
  logic        start_r_in = 1'b0;
  logic        start_l_in = 1'b0;
  logic [35:0] pix_word = '0;
  logic        invert = 1'b0;
  logic        start_r_out, start_r_oe, start_l_out, start_l_oe;
  logic [NC*6-1:0] col_data;

  col_loader i_col_loader (
    .clk(clk), .rst(rst), .dir_fwd(dir_fwd),
    .start_r_in(start_r_in), .start_l_in(start_l_in),
    .pix_word(pix_word), .invert(invert),
    .start_r_out(start_r_out), .start_r_oe(start_r_oe),
    .start_l_out(start_l_out), .start_l_oe(start_l_oe),
    .col_data(col_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  logic [5:0] exp_col [NC];
  bit         known   [NC];
  int         ptr = -1;
  bit         exp_carry = 1'b0;
  int         carry_seen_at = -1;
  int         edge_no = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic compare();
    int bad = -1;
    for (int c = 0; c < NC; c++)
      if (known[c] && bad < 0 && col_data[c*6 +: 6] !== exp_col[c]) bad = c;
    if (bad >= 0) check(0, tag, $sformatf("column %0d", bad),
                        col_data[bad*6 +: 6], exp_col[bad]);
    else check(1, tag, "columns", 0, 0);
    check(start_l_out === (exp_carry & dir_fwd) &&
          start_r_out === (exp_carry & ~dir_fwd), "R7", "carry pins",
          {start_l_out, start_r_out}, {exp_carry & dir_fwd, exp_carry & ~dir_fwd});
    check(start_l_oe === dir_fwd && start_r_oe === ~dir_fwd, "R8", "enables",
          {start_l_oe, start_r_oe}, {dir_fwd, ~dir_fwd});
  endtask

  task automatic cyc(input logic sr, input logic sl, input logic [35:0] w,
                     input logic inv);
    bit act;
    @(negedge clk);
    start_r_in = sr; start_l_in = sl; pix_word = w; invert = inv;
    @(posedge clk);
    #1;
    edge_no++;
    act = dir_fwd ? sr : sl;
    if (rst) begin
      ptr = -1; exp_carry = 0;
    end else if (act) begin
      ptr = 0; exp_carry = 0;
    end else if (ptr >= 0) begin
      for (int g = 0; g < NG; g++) begin
        int c = dir_fwd ? ptr*NG + g : NC - 1 - (ptr*NG + g);
        exp_col[c] = w[g*6 +: 6] ^ {6{inv}};
        known[c] = 1;
      end
      exp_carry = (ptr == NST - 1);
      ptr = (ptr == NST - 1) ? -1 : ptr + 1;
    end else begin
      exp_carry = 0;
    end
    if (exp_carry) carry_seen_at = edge_no;
    compare();
  endtask

  task automatic line(input bit inv_alt, input bit inv_const);
    int t0;
    cyc(dir_fwd, ~dir_fwd, 36'(64'($urandom) << 4), 1'b0);
    t0 = edge_no;
    for (int s = 0; s < NST; s++)
      cyc(0, 0, {$urandom, $urandom}, inv_alt ? s[0] : inv_const);
    cyc(0, 0, {$urandom, $urandom}, 1'b0);
    // R3: carry follows capture edge t0+64
    check(carry_seen_at == t0 + NST, "R3", "carry edge", carry_seen_at, t0 + NST);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin known[c] = 0; exp_col[c] = '0; end
    tag = "R1";
    cyc(0, 0, '0, 0); cyc(0, 0, '0, 0); cyc(0, 0, '0, 0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) cyc(0, 0, {$urandom, $urandom}, 0);

    tag = "R4"; dir_fwd = 1'b1;
    line(0, 0);
    tag = "R9";
    for (int i = 0; i < 10; i++) cyc(0, 0, {$urandom, $urandom}, $urandom);

    tag = "R2";
    cyc(0, 1, 36'h0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, {$urandom, $urandom}, 0);

    tag = "R5"; @(negedge clk); dir_fwd = 1'b0;
    line(0, 0);
    tag = "R2";
    cyc(1, 0, 36'h0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, {$urandom, $urandom}, 0);

    tag = "R6";
    line(1, 0);
    @(negedge clk); dir_fwd = 1'b1;
    line(0, 1);

    tag = "R10";
    cyc(1, 0, 36'h0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, {$urandom, $urandom}, 0);
    line(0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, {$urandom, $urandom}, 0);

    tag = "R1";
    @(negedge clk); rst = 1'b1;
    cyc(0, 0, '0, 0);
    check(start_l_out === 1'b0 && start_r_out === 1'b0, "R1", "reset pins",
          {start_l_out, start_r_out}, 0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) cyc(0, 0, {$urandom, $urandom}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule